// File: doc/BRIEF.md
# Receive Frame Acceptance and Status

This block watches the byte stream of one received Ethernet frame after the preamble and start delimiter have been removed. It decides whether the frame goes on to the receive FIFO. It also produces a 32-bit status word when the frame closes. The first six bytes are the destination address. As soon as the sixth byte is in, the block compares it with the station address and also classifies it as broadcast or multicast. Unless promiscuous mode is on, a unicast frame for another station is dropped at that point.

A frame that survives address filtering is not released at once. The block holds it back until 64 bytes have arrived, so that short collision fragments never reach the FIFO. If a frame ends before that mark, it is rejected. A frame longer than the programmed maximum length is never cut short. Instead it is marked as too long in its status word, and it can raise a babbling-receiver interrupt when that interrupt is enabled. The status word carries the frame length and eight condition flags. Some of these flags come from the address filter and the length check. The others are error flags that the surrounding receive path presents in the end-of-frame cycle.

Top module: `rx_frame_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fifo_accept`, `fifo_reject`, `stat_vld` and `babble_irq` are all 0.
- R2: The first received byte is compared with `station_addr[47:40]` and the sixth with `station_addr[7:0]`. If the six destination bytes differ from the station address, are not broadcast and are not multicast, and `promisc` is 0, then `fifo_reject` pulses for one cycle in the cycle right after the sixth byte is taken.
- R3: A destination of six 0xFF bytes is broadcast. The frame passes the filter, and its status word has bit 22 (BC) set and bit 21 (MC) clear.
- R4: A destination whose first byte has bit 0 set, and which is not broadcast, is multicast. The frame passes the filter, and its status word has bit 21 (MC) set.
- R5: With `promisc` at 1, a unicast frame for another station is kept. Its status word has bit 23 (M) set. Frames that matched, and broadcast or multicast frames, have bit 23 clear.
- R6: For a frame not yet rejected, `fifo_accept` pulses for one cycle in the cycle right after the 64th byte is taken. It pulses at most once per frame and never in the same cycle as `fifo_reject`.
- R7: When `frame_end` arrives for a frame that was neither accepted nor already rejected (a runt), `fifo_reject` pulses in the following cycle and no status word is produced.
- R8: For an accepted frame, `stat_vld` pulses in the cycle after `frame_end`. `stat_word[15:0]` then holds the number of bytes received, saturating at 0xFFFF, and bits 31:24 are 0.
- R9: Status bit 20 (LG) is set exactly when the byte count exceeds `max_len`. Every byte is still counted, so the frame is not truncated.
- R10: `babble_irq` pulses for one cycle in the cycle after the byte that brings the count to `max_len`+1, but only when `babble_en` is 1. It fires at most once per frame.
- R11: The flags are sampled in the `frame_end` cycle and placed in the status word as follows: bit 18 (CR) = `crc_err`, bit 17 (OV) = `fifo_ovf`, bit 16 (TR) = `trunc_flag`, bit 19 (NO) = `odd_bits`.
- R12: A frame rejected by the filter produces exactly one `fifo_reject` pulse, and no `fifo_accept` or `stat_vld` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | A frame byte is present on `byte_data` |
| byte_data | input | 8 | Received frame byte |
| frame_end | input | 1 | One-cycle pulse after the last byte of a frame |
| crc_err | input | 1 | Frame check failed (sampled with `frame_end`) |
| fifo_ovf | input | 1 | Receive FIFO overran (sampled with `frame_end`) |
| trunc_flag | input | 1 | Frame was truncated upstream (sampled with `frame_end`) |
| odd_bits | input | 1 | Bit count not a multiple of 8 (sampled with `frame_end`) |
| promisc | input | 1 | Keep unicast frames for other stations |
| babble_en | input | 1 | Interrupt mask bit for the babbling-receiver interrupt |
| max_len | input | 16 | Maximum frame length in bytes |
| station_addr | input | 48 | Own station address, first byte in bits 47:40 |
| fifo_accept | output | 1 | Frame accepted toward the FIFO |
| fifo_reject | output | 1 | Frame to be discarded by the FIFO |
| stat_vld | output | 1 | Status word valid |
| stat_word | output | 32 | Status word: flags in 23:16, length in 15:0 |
| babble_irq | output | 1 | Babbling-receiver interrupt pulse |

## Verification
Every result is registered once, so each result appears exactly one cycle after the clock edge on which its cause is sampled. The reject for a filtered address follows the sixth byte. The accept follows the 64th byte. Runt rejects and status words follow `frame_end`, and the interrupt follows the byte that crosses `max_len`. The bench drives inputs on falling edges and updates a behavioural model on each rising edge. It then compares every output with the model on the next falling edge, so any pulse that comes a cycle early or late, or that is missing, shows up as a mismatch. Per-frame pulse counts show the single-reject behaviour for filtered frames.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int LEN_W      = 16;
    localparam int ADDR_BYTES = 6;
    localparam int WINDOW     = 64;

    typedef struct packed {
        logic miss;
        logic bcast;
        logic mcast;
        logic too_long;
        logic odd_bits;
        logic crc_bad;
        logic ovf;
        logic trunc;
    } rx_flags_t;

    typedef struct packed {
        logic [7:0]       rsvd;
        rx_flags_t        flags;
        logic [LEN_W-1:0] len;
    } rx_status_t;

    function automatic rx_status_t make_status(input rx_flags_t f,
                                               input logic [LEN_W-1:0] l);
        rx_status_t s;
        s.rsvd  = '0;
        s.flags = f;
        s.len   = l;
        return s;
    endfunction

endpackage

// File: rtl/rxf_addr_track.sv
module rxf_addr_track #(
    parameter int ADDR_BYTES = 6,
    parameter int IDX_W      = $clog2(ADDR_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    byte_vld,
    input  logic [7:0]              byte_data,
    input  logic                    in_addr,
    input  logic [IDX_W-1:0]        byte_idx,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    uc_nxt,
    output logic                    bc_nxt,
    output logic                    mc_nxt,
    output logic                    uc_q,
    output logic                    bc_q,
    output logic                    mc_q
);

    logic [7:0] sa_b [ADDR_BYTES];
    logic       take;

    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_sa
        assign sa_b[g] = station_addr[8*(ADDR_BYTES-1-g) +: 8];
    end

    always_comb begin
        take   = byte_vld && in_addr;
        uc_nxt = uc_q && (!take || (byte_data == sa_b[byte_idx]));
        bc_nxt = bc_q && (!take || (byte_data == 8'hFF));
        mc_nxt = (take && (byte_idx == '0)) ? byte_data[0] : mc_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            uc_q <= 1'b1;
            bc_q <= 1'b1;
            mc_q <= 1'b0;
        end else begin
            uc_q <= uc_nxt;
            bc_q <= bc_nxt;
            mc_q <= mc_nxt;
        end
    end

    // R3: an all-ones destination can only stay broadcast if its first byte is odd
    a_r3_bcast_is_group: assert property (@(posedge clk) disable iff (rst)
        (bc_q && $past(take && byte_idx == '0)) |-> mc_q);

endmodule

// File: rtl/rxf_len_track.sv
module rxf_len_track #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             byte_vld,
    input  logic [LEN_W-1:0] max_len,
    input  logic             babble_en,
    output logic [LEN_W-1:0] cnt,
    output logic             over_q,
    output logic             babble_irq
);

    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt        <= '0;
            over_q     <= 1'b0;
            babble_irq <= 1'b0;
        end else begin
            babble_irq <= 1'b0;
            if (byte_vld) begin
                if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
                if (!over_q && (cnt >= max_len)) begin
                    over_q     <= 1'b1;
                    babble_irq <= babble_en;
                end
            end
        end
    end

    a_r10_babble_masked: assert property (@(posedge clk) disable iff (rst)
        babble_irq |-> $past(babble_en));

    a_r8_len_saturates: assert property (@(posedge clk) disable iff (rst)
        (!$past(clr) && $past(cnt) == CNT_MAX) |-> cnt == CNT_MAX);

endmodule

// File: rtl/rx_frame_filter.sv
module rx_frame_filter
    import rxf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    byte_vld,
    input  logic [7:0]              byte_data,
    input  logic                    frame_end,
    input  logic                    crc_err,
    input  logic                    fifo_ovf,
    input  logic                    trunc_flag,
    input  logic                    odd_bits,
    input  logic                    promisc,
    input  logic                    babble_en,
    input  logic [LEN_W-1:0]        max_len,
    input  logic [8*ADDR_BYTES-1:0] station_addr,
    output logic                    fifo_accept,
    output logic                    fifo_reject,
    output logic                    stat_vld,
    output logic [31:0]             stat_word,
    output logic                    babble_irq
);

    localparam int IDX_W = $clog2(ADDR_BYTES);
    localparam logic [LEN_W-1:0] ADDR_LAST = LEN_W'(ADDR_BYTES - 1);
    localparam logic [LEN_W-1:0] WIN_LAST  = LEN_W'(WINDOW - 1);

    logic [LEN_W-1:0] cnt;
    logic             over_q;
    logic             uc_nxt, bc_nxt, mc_nxt;
    logic             uc_q, bc_q, mc_q;
    logic             rej_q, acc_q;
    logic             pass_nxt;
    rx_flags_t        flags;

    rxf_len_track #(.LEN_W(LEN_W)) u_len (
        .clk        (clk),
        .rst        (rst),
        .clr        (frame_end),
        .byte_vld   (byte_vld),
        .max_len    (max_len),
        .babble_en  (babble_en),
        .cnt        (cnt),
        .over_q     (over_q),
        .babble_irq (babble_irq)
    );

    rxf_addr_track #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(IDX_W)) u_addr (
        .clk          (clk),
        .rst          (rst),
        .clr          (frame_end),
        .byte_vld     (byte_vld),
        .byte_data    (byte_data),
        .in_addr      (cnt < LEN_W'(ADDR_BYTES)),
        .byte_idx     (cnt[IDX_W-1:0]),
        .station_addr (station_addr),
        .uc_nxt       (uc_nxt),
        .bc_nxt       (bc_nxt),
        .mc_nxt       (mc_nxt),
        .uc_q         (uc_q),
        .bc_q         (bc_q),
        .mc_q         (mc_q)
    );

    always_comb begin
        pass_nxt       = uc_nxt || bc_nxt || mc_nxt || promisc;
        flags.bcast    = bc_q;
        flags.mcast    = mc_q && !bc_q;
        flags.miss     = !uc_q && !bc_q && !mc_q;
        flags.too_long = over_q;
        flags.odd_bits = odd_bits;
        flags.crc_bad  = crc_err;
        flags.ovf      = fifo_ovf;
        flags.trunc    = trunc_flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rej_q       <= 1'b0;
            acc_q       <= 1'b0;
            fifo_accept <= 1'b0;
            fifo_reject <= 1'b0;
            stat_vld    <= 1'b0;
            stat_word   <= '0;
        end else begin
            fifo_accept <= 1'b0;
            fifo_reject <= 1'b0;
            stat_vld    <= 1'b0;
            if (frame_end) begin
                if (acc_q) begin
                    stat_vld  <= 1'b1;
                    stat_word <= make_status(flags, cnt);
                end else if (!rej_q) begin
                    fifo_reject <= 1'b1;
                end
                rej_q <= 1'b0;
                acc_q <= 1'b0;
            end else if (byte_vld && !rej_q) begin
                if (cnt == ADDR_LAST && !pass_nxt) begin
                    rej_q       <= 1'b1;
                    fifo_reject <= 1'b1;
                end
                if (cnt == WIN_LAST) begin
                    acc_q       <= 1'b1;
                    fifo_accept <= 1'b1;
                end
            end
        end
    end

    a_r6_accept_reject_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fifo_accept && fifo_reject));

    a_r8_status_only_after_accept: assert property (@(posedge clk) disable iff (rst)
        stat_vld |-> $past(acc_q));

    a_r9_short_frame_not_long: assert property (@(posedge clk) disable iff (rst)
        (stat_vld && !stat_word[20]) |-> stat_word[15:0] <= $past(max_len));

    a_r7_runt_below_window: assert property (@(posedge clk) disable iff (rst)
        (fifo_reject && $past(frame_end)) |-> $past(cnt) < LEN_W'(WINDOW));

    a_r12_no_accept_when_rejected: assert property (@(posedge clk) disable iff (rst)
        $past(rej_q && !frame_end) |-> !fifo_accept);

endmodule

// File: tb/rx_frame_filter_tb.sv
module rx_frame_filter_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        frame_end = 1'b0;
    logic        crc_err = 1'b0, fifo_ovf = 1'b0, trunc_flag = 1'b0, odd_bits = 1'b0;
    logic        promisc = 1'b0;
    logic        babble_en = 1'b0;
    logic [15:0] max_len = 16'd1518;
    logic [47:0] station_addr = 48'h02_11_22_33_44_56;
    logic        fifo_accept, fifo_reject, stat_vld, babble_irq;
    logic [31:0] stat_word;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    string cur_req = "R1";

    rx_frame_filter u_dut (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_data(byte_data),
        .frame_end(frame_end), .crc_err(crc_err), .fifo_ovf(fifo_ovf),
        .trunc_flag(trunc_flag), .odd_bits(odd_bits), .promisc(promisc),
        .babble_en(babble_en), .max_len(max_len), .station_addr(station_addr),
        .fifo_accept(fifo_accept), .fifo_reject(fifo_reject), .stat_vld(stat_vld),
        .stat_word(stat_word), .babble_irq(babble_irq)
    );

    always #10 clk = ~clk;

    // behavioural reference model
    int         tcnt = 0;
    bit         m_rej = 0, m_acc = 0;
    logic [7:0] mda [6];
    bit         e_acc = 0, e_rej = 0, e_stat = 0, e_bab = 0;
    logic [31:0] e_word = '0;
    int acc_seen = 0, rej_seen = 0, stat_seen = 0, bab_seen = 0;

    always @(posedge clk) begin
        bit uc, bc, mc;
        e_acc = 0; e_rej = 0; e_stat = 0; e_bab = 0;
        if (rst) begin
            tcnt = 0; m_rej = 0; m_acc = 0;
        end else if (frame_end) begin
            if (m_acc) begin
                e_stat = 1;
                bc = 1; uc = 1;
                for (int i = 0; i < 6; i++) begin
                    if (mda[i] != 8'hFF) bc = 0;
                    if (mda[i] != station_addr[8*(5-i) +: 8]) uc = 0;
                end
                mc = mda[0][0] && !bc;
                e_word = 32'(tcnt > 65535 ? 65535 : tcnt);
                e_word[23] = !uc && !bc && !mc;
                e_word[22] = bc;
                e_word[21] = mc;
                e_word[20] = tcnt > int'(max_len);
                e_word[19] = odd_bits;
                e_word[18] = crc_err;
                e_word[17] = fifo_ovf;
                e_word[16] = trunc_flag;
            end else if (!m_rej) begin
                e_rej = 1;
            end
            tcnt = 0; m_rej = 0; m_acc = 0;
        end else if (byte_vld) begin
            if (tcnt < 6) mda[tcnt] = byte_data;
            tcnt++;
            if (tcnt == 6) begin
                bc = 1; uc = 1;
                for (int i = 0; i < 6; i++) begin
                    if (mda[i] != 8'hFF) bc = 0;
                    if (mda[i] != station_addr[8*(5-i) +: 8]) uc = 0;
                end
                if (!(uc || bc || mda[0][0] || promisc)) begin
                    m_rej = 1; e_rej = 1;
                end
            end
            if (tcnt == 64 && !m_rej) begin
                m_acc = 1; e_acc = 1;
            end
            if (tcnt == int'(max_len) + 1 && babble_en) e_bab = 1;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        check(cur_req, "fifo_accept", 32'(fifo_accept), 32'(e_acc));
        check(cur_req, "fifo_reject", 32'(fifo_reject), 32'(e_rej));
        check(cur_req, "stat_vld",    32'(stat_vld),    32'(e_stat));
        check(cur_req, "babble_irq",  32'(babble_irq),  32'(e_bab));
        if (e_stat) check(cur_req, "stat_word", stat_word, e_word);
        acc_seen  += int'(fifo_accept);
        rej_seen  += int'(fifo_reject);
        stat_seen += int'(stat_vld);
        bab_seen  += int'(babble_irq);
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send_frame(input logic [47:0] da, input int n,
                              input bit crc, input bit ovf, input bit tr, input bit odd);
        acc_seen = 0; rej_seen = 0; stat_seen = 0; bab_seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_vld  = 1'b1;
            byte_data = (i < 6) ? da[8*(5-i) +: 8] : 8'(i * 7 + 3);
        end
        @(negedge clk);
        byte_vld   = 1'b0;
        frame_end  = 1'b1;
        crc_err    = crc; fifo_ovf = ovf; trunc_flag = tr; odd_bits = odd;
        @(negedge clk);
        frame_end  = 1'b0;
        crc_err    = 1'b0; fifo_ovf = 1'b0; trunc_flag = 1'b0; odd_bits = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        cur_req = "R6";
        send_frame(station_addr, 70, 0, 0, 0, 0);
        check("R6", "accept count", 32'(acc_seen), 32'd1);

        cur_req = "R2";
        send_frame(48'h02_11_22_33_44_57, 70, 0, 0, 0, 0);
        check("R12", "reject count", 32'(rej_seen), 32'd1);
        check("R12", "accept count", 32'(acc_seen), 32'd0);
        check("R12", "status count", 32'(stat_seen), 32'd0);

        cur_req = "R3";
        send_frame(48'hFF_FF_FF_FF_FF_FF, 64, 0, 0, 0, 0);

        cur_req = "R4";
        send_frame(48'h01_00_5E_00_00_01, 100, 0, 0, 0, 0);

        cur_req = "R11";
        send_frame(48'h33_33_00_00_00_01, 90, 1, 1, 0, 0);
        send_frame(station_addr, 72, 0, 0, 1, 1);

        cur_req = "R5";
        promisc = 1'b1;
        send_frame(48'h04_AA_BB_CC_DD_EE, 80, 0, 0, 1, 1);
        send_frame(station_addr, 66, 0, 0, 0, 0);
        promisc = 1'b0;

        cur_req = "R7";
        send_frame(station_addr, 40, 0, 0, 0, 0);
        check("R7", "runt status count", 32'(stat_seen), 32'd0);
        send_frame(station_addr, 3, 0, 0, 0, 0);
        send_frame(station_addr, 63, 0, 0, 0, 0);

        cur_req = "R10";
        max_len = 16'd100; babble_en = 1'b1;
        send_frame(station_addr, 120, 0, 0, 0, 0);
        check("R10", "babble count", 32'(bab_seen), 32'd1);
        babble_en = 1'b0;
        send_frame(station_addr, 120, 0, 0, 0, 0);
        check("R10", "masked babble count", 32'(bab_seen), 32'd0);

        cur_req = "R9";
        send_frame(station_addr, 100, 0, 0, 0, 0);
        send_frame(station_addr, 101, 0, 0, 0, 0);

        cur_req = "R8";
        max_len = 16'hFFFF; babble_en = 1'b1;
        send_frame(station_addr, 65540, 0, 0, 0, 0);
        check("R8", "long frame babble count", 32'(bab_seen), 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule